// File: doc/BRIEF.md
# Paged Two-Wire Management Target

This block is a two-wire serial target that lets a host read and write a 256-byte management address space. It samples SCL and SDA with a fast system clock that runs at least sixteen times the bus rate. It detects START, repeated START and STOP, and it acknowledges only its own 7-bit device address. It answers only while the active-low select input is low. The first data byte of a write sets an internal byte pointer. Each following byte is stored at the pointer and advances it. A read returns bytes from the pointer onward, one byte per bus cycle, until the host answers with NACK.

The lower 128 bytes are always visible. The byte at address 127 selects which page appears in the upper 128-byte window. Some pages are implemented with storage and others are left empty; a parameter mask decides which. A small set of two-byte monitor words from the surrounding logic occupies a fixed run of lower addresses. When the high byte of a word is read, the block captures its low byte at the same moment, so a host that reads high then low always gets one consistent sample.

After reset the block stays silent for a parameter number of clock cycles before it responds. SDA is only ever pulled low, never driven high.

Top module: `tws_mgmt_target`

## Requirements
- R1: The block acknowledges the address byte A0h (device 1010000, write) and A1h (read). It acknowledges no other address byte and stays silent for the rest of that transfer.
- R2: While `sel_n` is high, the block never pulls SDA and acknowledges nothing.
- R3: For INIT_CYCLES clock cycles after reset, the block never pulls SDA and acknowledges nothing.
- R4: In a write, the first byte after A0h loads the pointer. Every later byte is stored at the pointer, the pointer then advances by one, and every byte is acknowledged.
- R5: After a repeated START and A1h, the block returns bytes starting at the pointer, advancing after each byte, while the host ACKs. A host NACK ends the transfer, and SDA is left released.
- R6: The pointer wraps inside its own half: 127 is followed by 0, and 255 is followed by 128 on the same selected page.
- R7: Address 127 holds the page select byte and reads back its value. Addresses 128 to 255 reach the page it names. The lower page reads the same whatever page is selected.
- R8: Pages whose bit is set in PAGE_PRESENT (default pages 0 and 3) store data. A page that is absent, or numbered UP_PAGES or above, reads as 00h and ignores writes.
- R9: Monitor word i sits at MON_BASE+2i (high byte, bits 15:8) and MON_BASE+2i+1 (low byte, bits 7:0). Reading the high byte captures the low byte, and a later read of the low byte returns that captured value. Host writes to these addresses have no effect.
- R10: A STOP returns the block to idle. Bits clocked after a STOP and without a new START are not acknowledged.
- R11: The level the block puts on SDA changes only while SCL is low, except when the block is being deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low target select |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| mon_words | input | MON_CNT*16 | Live monitor words, word i at bits [16i+15:16i] |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except to form START and STOP. Each SCL phase lasts several system clocks, so the two-stage synchronizer sees every edge. The select input changes only while the bus is idle. The bench's master model meets these conditions: it uses quarter-bit steps of ten clocks, sets data in the middle of the low phase, combines its SDA with the block's pull as a wired AND, and toggles select only between transactions.

// File: rtl/tws_mgmt_pkg.sv
package tws_mgmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_t;

  typedef enum logic [1:0] {
    SRC_LOW,
    SRC_AUX,
    SRC_UP,
    SRC_ZERO
  } rd_src_t;

  localparam logic [7:0] PAGE_REG_ADDR = 8'd127;

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return {p[7], p[6:0] + 7'd1};
  endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sel_n,
  output logic sda_s,
  output logic desel_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff, sda_ff, sel_ff;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      sel_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_in};
      sda_ff <= {sda_ff[STAGES-2:0], sda_in};
      sel_ff <= {sel_ff[STAGES-2:0], sel_n};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign desel_s   = sel_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/tws_target_fsm.sv
module tws_target_fsm
  import tws_mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ready,
  input  logic       desel,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_pull,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       rd_en,
  output logic [7:0] rd_addr
);

  bus_st_t    state;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sr, tx_sr, ptr;
  logic       rw, first, mack;

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      rd_en <= 1'b0;
      if (!ready || desel) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sr   <= {rx_sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (rx_sr[7:1] == DEV_ADDR) begin
                sda_pull <= 1'b1;
                rw       <= rx_sr[0];
                rd_en    <= rx_sr[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                tx_sr    <= rd_data;
                sda_pull <= ~rd_data[7];
                state    <= ST_RD;
              end else begin
                sda_pull <= 1'b0;
                first    <= 1'b1;
                state    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              rx_sr   <= {rx_sr[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              sda_pull <= 1'b1;
              state    <= ST_WR_ACK;
              if (first) begin
                ptr <= rx_sr;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= rx_sr;
                ptr     <= ptr_next(ptr);
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              first    <= 1'b0;
              bit_cnt  <= '0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_pull <= 1'b0;
                mack     <= 1'b0;
                ptr      <= ptr_next(ptr);
                rd_en    <= 1'b1;
                state    <= ST_RD_ACK;
              end else begin
                tx_sr    <= {tx_sr[6:0], 1'b0};
                sda_pull <= ~tx_sr[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sr    <= rd_data;
                sda_pull <= ~rd_data[7];
                bit_cnt  <= '0;
                state    <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tws_page_mem.sv
module tws_page_mem
  import tws_mgmt_pkg::*;
#(
  parameter int                  UP_PAGES     = 4,
  parameter logic [UP_PAGES-1:0] PAGE_PRESENT = 4'b1001,
  parameter int                  MON_BASE     = 22,
  parameter int                  MON_CNT      = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [7:0]             wr_addr,
  input  logic [7:0]             wr_data,
  input  logic                   rd_en,
  input  logic [7:0]             rd_addr,
  input  logic [MON_CNT*16-1:0]  mon_words,
  output logic [7:0]             rd_data
);

  localparam int         HALF   = 128;
  localparam int         PW     = (UP_PAGES > 1) ? $clog2(UP_PAGES) : 1;
  localparam int         MW     = (MON_CNT > 1) ? $clog2(MON_CNT) : 1;
  localparam logic [7:0] NPG    = 8'(UP_PAGES);
  localparam logic [7:0] MON_LO = 8'(MON_BASE);
  localparam logic [7:0] MON_HI = 8'(MON_BASE + 2 * MON_CNT);

  logic [7:0]    page_sel;
  logic [7:0]    lo_ram [HALF];
  logic [7:0]    lo_q, aux_q;
  logic [7:0]    up_q [UP_PAGES];
  logic [7:0]    snap [MON_CNT];
  logic [15:0]   mon_arr [MON_CNT];
  rd_src_t       src_q;
  logic [PW-1:0] upi_q;
  logic          mon_hit;
  logic [7:0]    mon_off;
  logic [MW-1:0] mon_idx;

  for (genvar i = 0; i < MON_CNT; i++) begin : g_mon
    assign mon_arr[i] = mon_words[i*16 +: 16];
  end

  assign mon_hit = (rd_addr >= MON_LO) && (rd_addr < MON_HI);
  assign mon_off = rd_addr - MON_LO;
  assign mon_idx = mon_off[MW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_sel <= '0;
    end else if (wr_en && wr_addr == PAGE_REG_ADDR) begin
      page_sel <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wr_addr[7]) lo_ram[wr_addr[6:0]] <= wr_data;
    if (rd_en) lo_q <= lo_ram[rd_addr[6:0]];
  end

  for (genvar p = 0; p < UP_PAGES; p++) begin : g_page
    if (PAGE_PRESENT[p]) begin : g_ram
      logic [7:0] ram [HALF];
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (wr_en && wr_addr[7] && page_sel == 8'(p)) ram[wr_addr[6:0]] <= wr_data;
        if (rd_en && rd_addr[7]) q <= ram[rd_addr[6:0]];
      end
      assign up_q[p] = q;
    end else begin : g_none
      assign up_q[p] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ZERO;
      upi_q <= '0;
      aux_q <= '0;
      for (int i = 0; i < MON_CNT; i++) snap[i] <= '0;
    end else if (rd_en) begin
      if (rd_addr[7]) begin
        if (page_sel < NPG) begin
          src_q <= SRC_UP;
          upi_q <= page_sel[PW-1:0];
        end else begin
          src_q <= SRC_ZERO;
        end
      end else if (rd_addr == PAGE_REG_ADDR) begin
        src_q <= SRC_AUX;
        aux_q <= page_sel;
      end else if (mon_hit) begin
        src_q <= SRC_AUX;
        if (mon_off[0]) begin
          aux_q <= snap[mon_idx];
        end else begin
          aux_q         <= mon_arr[mon_idx][15:8];
          snap[mon_idx] <= mon_arr[mon_idx][7:0];
        end
      end else begin
        src_q <= SRC_LOW;
      end
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_LOW: rd_data = lo_q;
      SRC_AUX: rd_data = aux_q;
      SRC_UP:  rd_data = up_q[upi_q];
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tws_mgmt_target.sv
module tws_mgmt_target #(
  parameter logic [6:0]          DEV_ADDR     = 7'h50,
  parameter int                  INIT_CYCLES  = 4000,
  parameter int                  UP_PAGES     = 4,
  parameter logic [UP_PAGES-1:0] PAGE_PRESENT = 4'b1001,
  parameter int                  MON_BASE     = 22,
  parameter int                  MON_CNT      = 4,
  parameter int                  SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull,
  input  logic [MON_CNT*16-1:0] mon_words
);

  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] init_cnt;
  logic          init_done;
  logic          sda_s, desel_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, rd_en;
  logic [7:0]    wr_addr, wr_data, rd_addr, rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else if (!init_done) begin
      if (init_cnt == CW'(INIT_CYCLES - 1)) init_done <= 1'b1;
      else                                  init_cnt  <= init_cnt + 1'b1;
    end
  end

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sel_n     (sel_n),
    .sda_s     (sda_s),
    .desel_s   (desel_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  tws_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ready     (init_done),
    .desel     (desel_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr)
  );

  tws_page_mem #(
    .UP_PAGES     (UP_PAGES),
    .PAGE_PRESENT (PAGE_PRESENT),
    .MON_BASE     (MON_BASE),
    .MON_CNT      (MON_CNT)
  ) u_mem (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .mon_words (mon_words),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/tws_mgmt_target_chk.sv
module tws_mgmt_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_in,
  input logic       sda_pull,
  input logic       desel_s,
  input logic       init_done,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] page_sel
);

  // R2: a deselected target releases SDA
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    desel_s |=> !sda_pull);

  // R3: silent during the start-up interval
  assert_init_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !sda_pull);

  // R7: the page byte changes only through a write to address 127
  assert_page_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 8'd127) |=> $stable(page_sel));

  // R11: the SDA level is changed only while SCL is low
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull) |-> (!$past(scl_in) || $past(desel_s)));

endmodule

bind tws_mgmt_target tws_mgmt_target_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_in    (scl_in),
  .sda_pull  (sda_pull),
  .desel_s   (desel_s),
  .init_done (init_done),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .page_sel  (u_mem.page_sel)
);

// File: tb/sim_tws_mgmt_target.sv
module sim_tws_mgmt_target;

  localparam int Q    = 10;
  localparam int INIT = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [63:0] mon = 64'h0;
  logic        sda_pull;
  wire         bus_sda = m_sda & ~sda_pull;

  always #2 clk = ~clk;

  tws_mgmt_target #(.INIT_CYCLES(INIT)) u0 (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .scl_in    (m_scl),
    .sda_in    (bus_sda),
    .sda_pull  (sda_pull),
    .mon_words (mon)
  );

  int checks = 0, errors = 0, viol_r11 = 0, viol_r2 = 0, desel_age = 0;
  bit done = 0;
  logic prev_pull = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic last_rel;

  // {page, addr, data, expected}
  localparam logic [31:0] VEC [7] = '{
    {8'd0, 8'd5,   8'h3C, 8'h3C},
    {8'd0, 8'd130, 8'h5A, 8'h5A},
    {8'd3, 8'd200, 8'hC3, 8'hC3},
    {8'd3, 8'd130, 8'h99, 8'h99},
    {8'd1, 8'd140, 8'h77, 8'h00},
    {8'd2, 8'd141, 8'h66, 8'h00},
    {8'd9, 8'd150, 8'h11, 8'h00}
  };

  always @(negedge clk) begin
    if (!rst) begin
      if (m_scl && sda_pull !== prev_pull && !sel_n) viol_r11++;
      desel_age = sel_n ? desel_age + 1 : 0;
      if (desel_age > 4 && sda_pull) viol_r2++;
    end
    prev_pull = sda_pull;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = ~bus_sda; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl = 1'b1; wq();
      b[i] = bus_sda; wq();
      m_scl = 1'b0; wq();
    end
    m_sda = ~give_ack; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_write(input logic [7:0] ptr, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    send_byte(8'hA0, a); ok = ok & a;
    send_byte(ptr, a);   ok = ok & a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); ok = ok & a;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] ptr, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    bus_start();
    send_byte(8'hA0, a); ok = ok & a;
    send_byte(ptr, a);   ok = ok & a;
    bus_start();
    send_byte(8'hA1, a); ok = ok & a;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    wq();
    last_rel = ~sda_pull;
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic ok, a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset pull", {7'd0, sda_pull}, 8'h00);

    // R3: no acknowledge during start-up interval
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk("R3 ack during init", {7'd0, a}, 8'h00);
    repeat (INIT) @(negedge clk);

    // R1: foreign address is ignored
    bus_start(); send_byte(8'hA4, a); bus_stop();
    chk("R1 foreign addr ack", {7'd0, a}, 8'h00);

    // R7/R8 table walk
    for (int k = 0; k < 7; k++) begin
      wbuf[0] = VEC[k][31:24];
      do_write(8'd127, 1, ok);
      wbuf[0] = VEC[k][15:8];
      do_write(VEC[k][23:16], 1, ok);
      chk("R1 R4 write acks", {7'd0, ok}, 8'h01);
      do_read(VEC[k][23:16], 1, ok);
      chk("R8 R7 paged readback", rbuf[0], VEC[k][7:0]);
    end
    do_read(8'd127, 1, ok);
    chk("R7 page byte readback", rbuf[0], 8'd9);
    wbuf[0] = 8'd0; do_write(8'd127, 1, ok);
    do_read(8'd130, 1, ok);
    chk("R7 page0 kept own data", rbuf[0], 8'h5A);
    do_read(8'd5, 1, ok);
    chk("R7 lower page independent", rbuf[0], 8'h3C);

    // R4/R5 sequential write and read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    do_write(8'd40, 4, ok);
    chk("R4 burst acks", {7'd0, ok}, 8'h01);
    do_read(8'd40, 4, ok);
    chk("R1 read address ack", {7'd0, ok}, 8'h01);
    for (int i = 0; i < 4; i++) chk("R5 sequential byte", rbuf[i], 8'h11 * 8'(i + 1));
    chk("R5 released after nack", {7'd0, last_rel}, 8'h01);

    // R6 lower wrap
    wbuf[0] = 8'hD0; wbuf[1] = 8'hD1; do_write(8'd0, 2, ok);
    wbuf[0] = 8'hE6; wbuf[1] = 8'h03; do_write(8'd126, 2, ok);
    do_read(8'd126, 4, ok);
    chk("R6 lower byte 126", rbuf[0], 8'hE6);
    chk("R7 page byte in burst", rbuf[1], 8'h03);
    chk("R6 lower wrap to 0", rbuf[2], 8'hD0);
    chk("R6 lower wrap to 1", rbuf[3], 8'hD1);

    // R6 upper wrap stays on page 0
    wbuf[0] = 8'd0; do_write(8'd127, 1, ok);
    wbuf[0] = 8'hF1; wbuf[1] = 8'hF2; wbuf[2] = 8'hF3; do_write(8'd254, 3, ok);
    do_read(8'd128, 1, ok);
    chk("R6 upper wrap to 128", rbuf[0], 8'hF3);
    do_read(8'd254, 3, ok);
    chk("R6 upper 254", rbuf[0], 8'hF1);
    chk("R6 upper 255", rbuf[1], 8'hF2);
    chk("R6 upper read wrap", rbuf[2], 8'hF3);

    // R9 monitor snapshot
    mon[15:0] = 16'h1234;
    do_read(8'd22, 1, ok);
    chk("R9 high byte", rbuf[0], 8'h12);
    mon[15:0] = 16'hABCD;
    do_read(8'd23, 1, ok);
    chk("R9 low from snapshot", rbuf[0], 8'h34);
    do_read(8'd22, 2, ok);
    chk("R9 pair high", rbuf[0], 8'hAB);
    chk("R9 pair low", rbuf[1], 8'hCD);
    wbuf[0] = 8'h55; wbuf[1] = 8'h66; do_write(8'd22, 2, ok);
    do_read(8'd22, 2, ok);
    chk("R9 write ignored high", rbuf[0], 8'hAB);
    chk("R9 write ignored low", rbuf[1], 8'hCD);

    // R2 deselected
    sel_n = 1'b1; wq();
    bus_start(); send_byte(8'hA0, a); bus_stop();
    chk("R2 write ack while deselected", {7'd0, a}, 8'h00);
    bus_start(); send_byte(8'hA1, a); recv_byte(b, 1'b0); bus_stop();
    chk("R2 read ack while deselected", {7'd0, a}, 8'h00);
    chk("R2 read data while deselected", b, 8'hFF);
    sel_n = 1'b0; wq();

    // R10 bits after STOP without START
    bus_start(); send_byte(8'hA0, a); bus_stop();
    m_scl = 1'b0; wq();
    send_byte(8'hA0, a);
    m_scl = 1'b1; wq();
    chk("R10 no ack without start", {7'd0, a}, 8'h00);
    bus_stop();
    do_read(8'd40, 1, ok);
    chk("R10 recovers after stop", rbuf[0], 8'h11);

    chk("R11 sda change while scl high", 8'(viol_r11), 8'h00);
    chk("R2 pull while deselected", 8'(viol_r2), 8'h00);
    finish_run();
  end

endmodule